// File: doc/BRIEF.md
# Inbound Requester-to-Partition Classifier

This block sits on the inbound side of a PCIe root complex and sorts every incoming request by the partition it belongs to. Each request carries a 16-bit requester ID (bus, device, function). The low bits of that ID index a partition table, and the table returns the partition number that the freeze gate downstream uses to drop or pass traffic. The same lookup serves three request classes. Memory reads and writes are DMA. Memory writes that land in one of two address windows are MSIs. Error messages form the third class.

DMA traffic is split between two per-partition address windows by one high address bit. An MSI write is turned into an interrupt index in the range 0 to 2047. That index reads a descriptor table, and the descriptor holds the partition number that may raise the interrupt. The interrupt fires only when the descriptor's partition equals the requester's partition. On a mismatch the interrupt is dropped and a one-cycle error pulse carrying the requester ID is raised. An error message receives its partition number and nothing else.

Both tables are memories with a one-cycle registered read, loaded through a simple write port. The request path uses valid/ready flow control. Each accepted request produces exactly one result, in order, one cycle later unless the output is stalled.

Top module: `ptn_lookup`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `out_valid` is 0 and `in_ready` is 1.
- R2: A request accepted on a rising edge (`in_valid` and `in_ready` both high) appears on the output in the next cycle. `in_ready` equals `!out_valid || out_ready`. Results leave in acceptance order, one per accepted request.
- R3: `out_pe` is the partition-table entry at index `in_rid[RID_IDX_W-1:0]` for every request class. The requester ID bits above the index are ignored for the lookup but are returned unchanged on `out_rid`.
- R4: A request with `in_type[1]` = 1 (error message, codes 2 and 3) yields `out_kind` = 3 whatever its address. It never fires an interrupt and never raises `err_pulse`.
- R5: A DMA request yields `out_kind` = 0 when address bit 59 is 0 and `out_kind` = 1 when it is 1. A read (`in_type` = 0) is always DMA.
- R6: A write (`in_type` = 1) whose address bits [63:16] equal 0x0000_0000_FFFF is an MSI (`out_kind` = 2). This check takes priority over the DMA window bit, and any other address is not an MSI through this window.
- R7: A write whose address bits [63:16] equal `msi_hi_base[63:16]` is an MSI (`out_kind` = 2). An address one 64 KB step outside that range is not.
- R8: For an MSI, `out_irq` = {address bits [4:2], `in_data[7:0]`}, an index from 0 to 2047.
- R9: On the output handshake of an MSI, `irq_fire` pulses if the descriptor-table entry at `out_irq` equals `out_pe`, and `out_msi_ok` shows the same result. Otherwise `err_pulse` pulses with `err_rid` equal to the requester ID. The two pulses never coincide, and neither pulses for non-MSI results.
- R10: While `out_valid` is 1 and `out_ready` is 0, every output field holds its value into the next cycle.
- R11: A configuration write with `cfg_sel` = 0 stores `cfg_data` into the partition table at `cfg_addr`. With `cfg_sel` = 1 it stores into the descriptor table. A lookup accepted in the same cycle as a write to its entry returns the old value, and later lookups return the new one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Table write strobe |
| cfg_sel | input | 1 | Table select: 0 partition table, 1 descriptor table |
| cfg_addr | input | 11 | Table entry index |
| cfg_data | input | 8 | Partition number to store |
| msi_hi_base | input | 64 | Base of the high 64 KB MSI window |
| in_valid | input | 1 | Request valid |
| in_ready | output | 1 | Request accepted when high with in_valid |
| in_type | input | 2 | 0 read, 1 write, 2 or 3 error message |
| in_rid | input | 16 | Requester ID |
| in_addr | input | 64 | Request address |
| in_data | input | 8 | MSI data field |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Result consumed when high with out_valid |
| out_kind | output | 2 | 0 DMA window 0, 1 DMA window 1, 2 MSI, 3 error message |
| out_pe | output | 8 | Partition number of the requester |
| out_irq | output | 11 | Interrupt index (meaningful for MSI) |
| out_msi_ok | output | 1 | MSI authorized |
| out_rid | output | 16 | Requester ID of the result |
| irq_fire | output | 1 | Authorized interrupt, one per handshake |
| err_pulse | output | 1 | Rejected MSI, one per handshake |
| err_rid | output | 16 | Requester ID of the rejected MSI |

## Verification
A corrupted stage register or a table read taken at the wrong time shows up at the output in the very next handshake. It appears as a wrong partition number, a wrong class code or a lost or duplicated result. The scoreboard flags it on that cycle. A read enable that is not held off during a stall changes `out_pe` while the result is blocked, and the hold check catches this one cycle into the stall. A wrong descriptor compare shows as `irq_fire` and `err_pulse` swapped on the first MSI whose two partitions differ. The bench therefore programs both matching and mismatching descriptors.

// File: rtl/ptn_pkg.sv
package ptn_pkg;

    // request type codes on in_type
    localparam logic [1:0] TY_READ  = 2'd0;
    localparam logic [1:0] TY_WRITE = 2'd1;

    // result classes on out_kind
    typedef enum logic [1:0] {
        KIND_DMA0 = 2'd0,
        KIND_DMA1 = 2'd1,
        KIND_MSI  = 2'd2,
        KIND_ERR  = 2'd3
    } kind_e;

endpackage

// File: rtl/ptn_ram.sv
// Single write port, single registered read port; read returns old data
// when the same entry is written in that cycle.
module ptn_ram #(
    parameter int DEPTH = 256,
    parameter int W     = 8,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic          re,
    input  logic [AW-1:0] raddr,
    output logic [W-1:0]  rdata
);

    logic [W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem_q[waddr] <= wdata;
        end
        if (re) begin
            rdata <= mem_q[raddr];
        end
    end

endmodule

// File: rtl/ptn_decode.sv
// Combinational classification of one inbound request.
module ptn_decode
    import ptn_pkg::*;
#(
    parameter int ADDR_W       = 64,
    parameter int IRQ_W        = 11,
    parameter int MSI_DATA_W   = 8,
    parameter int DMA_SEL_BIT  = 59,
    parameter int MSI_WIN_BITS = 16
) (
    input  logic [1:0]            req_type,
    input  logic [ADDR_W-1:0]     addr,
    input  logic [MSI_DATA_W-1:0] data,
    input  logic [ADDR_W-1:0]     msi_base,
    output logic [1:0]            kind,
    output logic [IRQ_W-1:0]      irq
);

    localparam int TAG_W   = ADDR_W - MSI_WIN_BITS;
    localparam int IRQ_AB  = IRQ_W - MSI_DATA_W;
    localparam logic [TAG_W-1:0] LO_TAG =
        TAG_W'((64'd1 << (32 - MSI_WIN_BITS)) - 64'd1);

    logic lo_hit, hi_hit, is_msg, is_wr;

    always_comb begin
        lo_hit = (addr[ADDR_W-1:MSI_WIN_BITS] == LO_TAG);
        hi_hit = (addr[ADDR_W-1:MSI_WIN_BITS] == msi_base[ADDR_W-1:MSI_WIN_BITS]);
        is_msg = req_type[1];
        is_wr  = (req_type == TY_WRITE);
        if (is_msg) begin
            kind = KIND_ERR;
        end else if (is_wr && (lo_hit || hi_hit)) begin
            kind = KIND_MSI;
        end else if (addr[DMA_SEL_BIT]) begin
            kind = KIND_DMA1;
        end else begin
            kind = KIND_DMA0;
        end
        irq = {addr[2 +: IRQ_AB], data};
    end

    logic unused_bits;
    assign unused_bits = ^{addr[MSI_WIN_BITS-1:2+IRQ_AB], addr[1:0],
                           msi_base[MSI_WIN_BITS-1:0]};

endmodule

// File: rtl/ptn_lookup.sv
module ptn_lookup
    import ptn_pkg::*;
#(
    parameter int ADDR_W       = 64,
    parameter int RID_W        = 16,
    parameter int RID_IDX_W    = 8,
    parameter int PE_W         = 8,
    parameter int IRQ_W        = 11,
    parameter int MSI_DATA_W   = 8,
    parameter int DMA_SEL_BIT  = 59,
    parameter int MSI_WIN_BITS = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cfg_we,
    input  logic                  cfg_sel,
    input  logic [((RID_IDX_W > IRQ_W) ? RID_IDX_W : IRQ_W)-1:0] cfg_addr,
    input  logic [PE_W-1:0]       cfg_data,
    input  logic [ADDR_W-1:0]     msi_hi_base,
    input  logic                  in_valid,
    output logic                  in_ready,
    input  logic [1:0]            in_type,
    input  logic [RID_W-1:0]      in_rid,
    input  logic [ADDR_W-1:0]     in_addr,
    input  logic [MSI_DATA_W-1:0] in_data,
    output logic                  out_valid,
    input  logic                  out_ready,
    output logic [1:0]            out_kind,
    output logic [PE_W-1:0]       out_pe,
    output logic [IRQ_W-1:0]      out_irq,
    output logic                  out_msi_ok,
    output logic [RID_W-1:0]      out_rid,
    output logic                  irq_fire,
    output logic                  err_pulse,
    output logic [RID_W-1:0]      err_rid
);

    localparam int RID_DEPTH = 1 << RID_IDX_W;
    localparam int IRQ_DEPTH = 1 << IRQ_W;

    typedef struct packed {
        logic             v;
        logic [1:0]       kind;
        logic [IRQ_W-1:0] irq;
        logic [RID_W-1:0] rid;
    } stage_t;

    stage_t st_d, st_q;

    logic [1:0]       dec_kind;
    logic [IRQ_W-1:0] dec_irq;
    logic             advance, accept;
    logic [PE_W-1:0]  rid_pe, desc_pe;
    logic             is_msi, pe_match, fire;

    ptn_decode #(
        .ADDR_W      (ADDR_W),
        .IRQ_W       (IRQ_W),
        .MSI_DATA_W  (MSI_DATA_W),
        .DMA_SEL_BIT (DMA_SEL_BIT),
        .MSI_WIN_BITS(MSI_WIN_BITS)
    ) u_dec (
        .req_type(in_type),
        .addr    (in_addr),
        .data    (in_data),
        .msi_base(msi_hi_base),
        .kind    (dec_kind),
        .irq     (dec_irq)
    );

    // partition table, indexed by the low requester-ID bits
    ptn_ram #(.DEPTH(RID_DEPTH), .W(PE_W)) u_rid_tab (
        .clk  (clk),
        .we   (cfg_we && !cfg_sel),
        .waddr(cfg_addr[RID_IDX_W-1:0]),
        .wdata(cfg_data),
        .re   (accept),
        .raddr(in_rid[RID_IDX_W-1:0]),
        .rdata(rid_pe)
    );

    // interrupt descriptor table, indexed by the interrupt number
    ptn_ram #(.DEPTH(IRQ_DEPTH), .W(PE_W)) u_desc_tab (
        .clk  (clk),
        .we   (cfg_we && cfg_sel),
        .waddr(cfg_addr[IRQ_W-1:0]),
        .wdata(cfg_data),
        .re   (accept),
        .raddr(dec_irq),
        .rdata(desc_pe)
    );

    assign advance = !st_q.v || out_ready;
    assign accept  = in_valid && advance;

    always_comb begin
        st_d = st_q;
        if (advance) begin
            st_d.v = in_valid;
            if (in_valid) begin
                st_d.kind = dec_kind;
                st_d.irq  = dec_irq;
                st_d.rid  = in_rid;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign is_msi   = (st_q.kind == KIND_MSI);
    assign pe_match = (desc_pe == rid_pe);
    assign fire     = st_q.v && out_ready;

    assign in_ready   = advance;
    assign out_valid  = st_q.v;
    assign out_kind   = st_q.kind;
    assign out_pe     = rid_pe;
    assign out_irq    = st_q.irq;
    assign out_rid    = st_q.rid;
    assign out_msi_ok = is_msi && pe_match;
    assign irq_fire   = fire && is_msi && pe_match;
    assign err_pulse  = fire && is_msi && !pe_match;
    assign err_rid    = st_q.rid;

    // R2: one-cycle latency from acceptance
    a_r2_latency: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready |=> out_valid);

    // R10: blocked result holds still
    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_kind)
            && $stable(out_pe) && $stable(out_irq) && $stable(out_rid));

    // R4: error messages are classified as such
    a_r4_msg_kind: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready && in_type[1] |=> out_kind == KIND_ERR);

    // R5: reads never become MSIs
    a_r5_read_dma: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready && in_type == TY_READ |=> out_kind != KIND_MSI);

    // R9: fire and reject are exclusive and only on a handshake
    a_r9_excl: assert property (@(posedge clk) disable iff (!rst_n)
        irq_fire |-> !err_pulse && out_valid && out_ready);

endmodule

// File: tb/tb_ptn_lookup.sv
`timescale 1ns/1ps
module tb_ptn_lookup;

    localparam logic [63:0] HI_BASE = 64'h0000_0040_0000_0000;

    typedef struct {
        logic [1:0]  kind;
        logic [7:0]  pe;
        logic [10:0] irq;
        logic        ok;
        logic [15:0] rid;
        string       tag;
    } exp_t;

    logic        clk = 0, rst_n = 0;
    logic        cfg_we = 0, cfg_sel = 0;
    logic [10:0] cfg_addr = '0;
    logic [7:0]  cfg_data = '0;
    logic        in_valid = 0, in_ready;
    logic [1:0]  in_type = '0;
    logic [15:0] in_rid = '0;
    logic [63:0] in_addr = '0;
    logic [7:0]  in_data = '0;
    logic        out_valid, out_ready = 1;
    logic [1:0]  out_kind;
    logic [7:0]  out_pe;
    logic [10:0] out_irq;
    logic        out_msi_ok, irq_fire, err_pulse;
    logic [15:0] out_rid, err_rid;

    ptn_lookup dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_addr(cfg_addr), .cfg_data(cfg_data), .msi_hi_base(HI_BASE),
        .in_valid(in_valid), .in_ready(in_ready), .in_type(in_type),
        .in_rid(in_rid), .in_addr(in_addr), .in_data(in_data),
        .out_valid(out_valid), .out_ready(out_ready), .out_kind(out_kind),
        .out_pe(out_pe), .out_irq(out_irq), .out_msi_ok(out_msi_ok),
        .out_rid(out_rid), .irq_fire(irq_fire), .err_pulse(err_pulse),
        .err_rid(err_rid)
    );

    always #4 clk = ~clk;

    int   n_chk = 0, n_fail = 0;
    bit   stall_en = 0, done = 0;
    exp_t exp_q[$];
    logic [7:0] m_rid [256];
    logic [7:0] m_desc [2048];

    task automatic chk(input bit good, input string req, input string what,
                       input longint act, input longint expv);
        n_chk++;
        if (!good) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, expv);
        end
    endtask

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    function automatic logic [1:0] exp_kind(logic [1:0] ty, logic [63:0] a);
        if (ty[1]) return 2'd3;
        if (ty == 2'd1 && (a[63:16] == 48'h0000_0000_FFFF || a[63:16] == HI_BASE[63:16]))
            return 2'd2;
        return a[59] ? 2'd1 : 2'd0;
    endfunction

    task automatic cfg(input bit sel, input int idx, input logic [7:0] val);
        cfg_we = 1; cfg_sel = sel; cfg_addr = 11'(idx); cfg_data = val;
        @(posedge clk); #2;
        cfg_we = 0;
        if (sel) m_desc[idx] = val; else m_rid[idx] = val;
    endtask

    function automatic exp_t mk(logic [1:0] ty, logic [15:0] rid, logic [63:0] a,
                                logic [7:0] d, string tag);
        exp_t e;
        e.kind = exp_kind(ty, a);
        e.pe   = m_rid[rid[7:0]];
        e.irq  = {a[4:2], d};
        e.ok   = (e.kind == 2'd2) && (m_desc[e.irq] == e.pe);
        e.rid  = rid;
        e.tag  = tag;
        return e;
    endfunction

    task automatic send(input logic [1:0] ty, input logic [15:0] rid,
                        input logic [63:0] a, input logic [7:0] d, input string tag);
        bit hs;
        in_valid = 1; in_type = ty; in_rid = rid; in_addr = a; in_data = d;
        do begin
            @(negedge clk); hs = in_ready;
            @(posedge clk);
        end while (!hs);
        exp_q.push_back(mk(ty, rid, a, d, tag));
        #2 in_valid = 0;
    endtask

    // output backpressure
    initial forever begin
        @(posedge clk); #1;
        out_ready = stall_en ? ($urandom_range(0, 2) != 0) : 1'b1;
    end

    // monitor: scoreboard compare and stall hold
    bit          was_stalled = 0;
    logic [1:0]  h_kind;
    logic [7:0]  h_pe;
    logic [10:0] h_irq;
    logic [15:0] h_rid;
    always @(negedge clk) begin
        if (rst_n) begin
            if (was_stalled) begin
                chk(out_valid && out_kind == h_kind && out_pe == h_pe &&
                    out_irq == h_irq && out_rid == h_rid, "R10", "held result",
                    {out_kind, out_pe, out_rid}, {h_kind, h_pe, h_rid});
            end
            was_stalled = out_valid && !out_ready;
            h_kind = out_kind; h_pe = out_pe; h_irq = out_irq; h_rid = out_rid;
            if (out_valid && out_ready) begin
                if (exp_q.size() == 0) begin
                    chk(0, "R2", "unexpected result", out_rid, 0);
                end else begin
                    exp_t e;
                    bit msi, good;
                    e = exp_q.pop_front();
                    msi = (e.kind == 2'd2);
                    good = (out_kind == e.kind) && (out_pe == e.pe) && (out_rid == e.rid)
                        && (!msi || (out_irq == e.irq && out_msi_ok == e.ok))
                        && (irq_fire == (msi && e.ok)) && (err_pulse == (msi && !e.ok))
                        && (!err_pulse || err_rid == e.rid);
                    chk(good, e.tag, "kind/pe/rid/irq/fire/err",
                        {out_kind, out_pe, out_rid, out_irq, irq_fire, err_pulse},
                        {e.kind, e.pe, e.rid, e.irq, msi && e.ok, msi && !e.ok});
                end
            end
        end
    end

    // watchdog
    initial begin
        repeat (200000) @(posedge clk);
        chk(0, "R2", "watchdog expired", 0, 1);
        summary();
    end

    initial begin
        // R1: reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(!out_valid && in_ready, "R1", "during reset", {out_valid, in_ready}, 2'b01);
        @(posedge clk); #2 rst_n = 1;
        @(negedge clk);
        chk(!out_valid && in_ready, "R1", "after reset", {out_valid, in_ready}, 2'b01);
        @(posedge clk); #2;

        // R11: load both tables
        for (int i = 0; i < 256; i++) cfg(0, i, 8'((i * 37 + 5) & 255));
        for (int j = 0; j < 2048; j++) cfg(1, j, 8'(j) ^ 8'h5A);

        // R3 / R5: DMA windows and index bits
        send(2'd0, 16'h0000, 64'h0000_0000_1000_0000, 8'h00, "R5");
        send(2'd1, 16'h00FF, 64'h0800_0000_0000_0040, 8'h00, "R5");
        send(2'd0, 16'hAB05, 64'h0800_0000_FFFF_0000, 8'h00, "R3");
        send(2'd1, 16'h1205, 64'h0000_0001_2000_0000, 8'h00, "R3");

        // R4: error messages, even at an MSI address
        send(2'd2, 16'h0310, 64'h0000_0000_FFFF_0004, 8'h11, "R4");
        send(2'd3, 16'h0311, 64'h0800_0000_0000_0000, 8'h22, "R4");

        // R6: low window boundaries
        send(2'd0, 16'h0107, 64'h0000_0000_FFFF_0014, 8'h3C, "R6");
        send(2'd1, 16'h0107, 64'h0000_0000_FFFE_FFFC, 8'h3C, "R6");
        send(2'd1, 16'h0107, 64'h0000_0001_FFFF_0014, 8'h3C, "R6");

        // R8 / R9: matching and mismatching descriptors
        cfg(1, 11'h53C, m_rid[8'h07]);
        send(2'd1, 16'h0107, 64'h0000_0000_FFFF_0014, 8'h3C, "R9");
        cfg(1, 11'h7FF, m_rid[8'h20] ^ 8'h01);
        send(2'd1, 16'h4420, 64'h0000_0000_FFFF_FFFC, 8'hFF, "R9");
        cfg(1, 11'h000, m_rid[8'h21]);
        send(2'd1, 16'h0021, 64'h0000_0000_FFFF_0000, 8'h00, "R8");

        // R7: high window and its neighbours
        cfg(1, 11'h2A5, m_rid[8'h33]);
        send(2'd1, 16'h0033, HI_BASE + 64'h0000_0000_0000_0008, 8'hA5, "R7");
        send(2'd1, 16'h0033, HI_BASE + 64'h0000_0000_0001_0000, 8'hA5, "R7");
        send(2'd1, 16'h0033, HI_BASE - 64'h0000_0000_0000_0004, 8'hA5, "R7");
        send(2'd0, 16'h0033, HI_BASE + 64'h0000_0000_0000_0008, 8'hA5, "R5");

        // R11: write and lookup in the same cycle
        repeat (3) @(posedge clk); #2;
        cfg_we = 1; cfg_sel = 0; cfg_addr = 11'h044; cfg_data = 8'hC3;
        in_valid = 1; in_type = 2'd0; in_rid = 16'h0044;
        in_addr = 64'h0000_0000_0000_1000; in_data = 8'h00;
        exp_q.push_back(mk(2'd0, 16'h0044, in_addr, 8'h00, "R11"));
        @(posedge clk); #2;
        cfg_we = 0; in_valid = 0; m_rid[8'h44] = 8'hC3;
        send(2'd0, 16'h0044, 64'h0000_0000_0000_1000, 8'h00, "R11");

        // R2 / R10: mixed burst under backpressure
        stall_en = 1;
        for (int i = 0; i < 80; i++) begin
            logic [63:0] a;
            case (i % 5)
                0: a = 64'h0000_0000_FFFF_0000 | 64'(((i % 8)) << 2);
                1: a = HI_BASE | 64'((i % 8) << 2);
                2: a = 64'h0800_0000_0000_0000 | 64'(i << 8);
                3: a = 64'(i << 12);
                default: a = 64'h0000_0000_FFFE_0000;
            endcase
            send(2'(i % 4), 16'(i * 29 + 16'h0100), a, 8'(i * 7), "R2");
        end
        stall_en = 0;
        repeat (20) @(posedge clk);
        chk(exp_q.size() == 0, "R2", "results outstanding", exp_q.size(), 0);
        summary();
    end

endmodule